// File: doc/BRIEF.md
# Ping-Pong Multiplexed Digit Scanner

This block scans a three-digit, common-cathode seven-segment display. The display words live in a lookup memory as three-word records. A record at base address 3n holds one word per digit. Each 12-bit word carries the segment pattern for that digit and the active-low enables that select it. The block sends record addresses to the memory. It absorbs the memory's one-clock read latency and latches each returned word onto parallel outputs. Each word then stays on the outputs for a fixed dwell time, so the three digits appear to be lit at once.

The digits are not visited in a modulo-three rotation. The address offset moves up and down across the record in the order 0, 1, 2, 1, 0, 1, 2, and so on. A direction bit flips each time the scanner leaves the middle digit. A locked flag from the upstream value locator gates the scan. While that flag is low, every digit is blanked and the scan returns to its start. When the flag rises again, scanning restarts from the first digit of the record given on the base input. The decimal point does not come from the memory word. It is derived from a range switch and from which digit is lit.

Top module: `pingPongScanner`

## Requirements
- R1: While reset is asserted, `digitEnN` is 3'b111, `segOut` is 0, `dpOut` is 0, and `memAddr` equals `recordBase`.
- R2: A latched word from address `recordBase`+k drives `segOut[6:0]` from word bits 11 down to 5, with `segOut[6]` taken from bit 11.
- R3: A latched word drives `digitEnN[0]` (digit 1) from word bit 3, `digitEnN[1]` (digit 2) from bit 2 and `digitEnN[2]` (digit 3) from bit 1. A digit is lit when its enable is 0. Word bits 4 and 0 have no effect on any output.
- R4: While locked, the address offset from `recordBase` follows 0, 1, 2, 1, 0, 1, 2, ... It changes by exactly one per step and never jumps between 2 and 0.
- R5: While locked, each word stays on the outputs for exactly `DWELL_CYCLES` clock cycles before the next word replaces it.
- R6: After `locked` is first sampled high at a rising edge, the outputs stay blank at the next edge. The word at offset 0 appears at the third rising edge.
- R7: The edge after `locked` is sampled low drives `digitEnN` to 3'b111 and `segOut` to 0. The next locked period restarts at offset 0, going upward.
- R8: `dpOut` follows the range switch at once. With `rangeHigh`=0, `dpOut` is 1 exactly while digit 1 is lit. With `rangeHigh`=1, `dpOut` is 1 exactly while digit 2 is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locked | input | 1 | Record base is valid; scanning enabled |
| rangeHigh | input | 1 | Range switch: 0 low range, 1 high range |
| recordBase | input | ADDR_W | Address of the record's first word (3n) |
| memData | input | 12 | Memory read data, valid one clock after address |
| memAddr | output | ADDR_W | Memory read address |
| segOut | output | 7 | Segment lines, active high |
| digitEnN | output | 3 | Digit enables, active low, index 0 is digit 1 |
| dpOut | output | 1 | Decimal point line, active high |

## Verification
The bound checker watches several rules on every cycle. Blanking follows within one edge of losing lock. The address always lies inside the current record and only moves by single steps. At most one digit is lit at a time. A lit point always comes with a lit digit. A counter also checks that each word is held for the full dwell between two lit words. Only the bench's scenarios can show the rest: that the right memory word reaches the right output bits, that the unused word bits are ignored, the exact first-word latency after lock, and that a relock mid-scan restarts upward from the first digit.

// File: rtl/scanPkg.sv
package scanPkg;
  localparam int WORD_W = 12;
  localparam int SEG_N  = 7;
  localparam int DIG_N  = 3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_READ,
    PH_SHOW
  } phase_t;

  typedef struct packed {
    logic blank;    // lock lost: clear outputs and scan position
    logic advance;  // step the ping-pong position
    logic load;     // memory data valid, latch word
  } scanStrobe_t;
endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
#(
  parameter int DWELL_CYCLES = 60000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        locked,
  output scanStrobe_t strobe
);
  localparam int CNT_W = $clog2(DWELL_CYCLES) + 1;
  // the next address is issued two cycles early so the read latency hides under the dwell
  localparam logic [CNT_W-1:0] ADV_AT = CNT_W'(DWELL_CYCLES - 3);

  phase_t           phase;
  logic [CNT_W-1:0] dwellCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !locked) begin
      phase    <= PH_IDLE;
      dwellCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: phase <= PH_ADDR;
        PH_ADDR: phase <= PH_READ;
        PH_READ: begin
          phase    <= PH_SHOW;
          dwellCnt <= '0;
        end
        default: begin
          dwellCnt <= dwellCnt + 1'b1;
          if (dwellCnt == ADV_AT) phase <= PH_ADDR;
        end
      endcase
    end
  end

  always_comb begin
    strobe.blank   = !locked;
    strobe.advance = locked && (phase == PH_SHOW) && (dwellCnt == ADV_AT);
    strobe.load    = locked && (phase == PH_READ);
  end
endmodule

// File: rtl/scanPath.sv
module scanPath
  import scanPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strobe,
  input  logic              rangeHigh,
  input  logic [ADDR_W-1:0] recordBase,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SEG_N-1:0]  segOut,
  output logic [DIG_N-1:0]  digitEnN,
  output logic              dpOut
);
  localparam int SEG_LSB = WORD_W - SEG_N;  // bit 5

  logic [1:0] slot;   // offset within the record
  logic       goUp;   // direction taken when leaving the middle digit
  logic       unusedBits;

  assign unusedBits = ^{memData[4], memData[0]};

  always_ff @(posedge clk) begin
    if (!rstN || strobe.blank) begin
      slot <= 2'd0;
      goUp <= 1'b1;
    end else if (strobe.advance) begin
      case (slot)
        2'd1: begin
          slot <= goUp ? 2'd2 : 2'd0;
          goUp <= !goUp;
        end
        default: slot <= 2'd1;
      endcase
    end
  end

  assign memAddr = recordBase + ADDR_W'(slot);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.blank) begin
      segOut   <= '0;
      digitEnN <= '1;
    end else if (strobe.load) begin
      segOut <= memData[WORD_W-1:SEG_LSB];
      for (int d = 0; d < DIG_N; d++) begin
        digitEnN[d] <= memData[3-d];
      end
    end
  end

  assign dpOut = rangeHigh ? !digitEnN[1] : !digitEnN[0];
endmodule

// File: rtl/pingPongScanner.sv
module pingPongScanner #(
  parameter int DWELL_CYCLES = 60000,
  parameter int ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locked,
  input  logic              rangeHigh,
  input  logic [ADDR_W-1:0] recordBase,
  input  logic [11:0]       memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [6:0]        segOut,
  output logic [2:0]        digitEnN,
  output logic              dpOut
);
  scanPkg::scanStrobe_t strobe;

  scanCtrl #(.DWELL_CYCLES(DWELL_CYCLES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .locked (locked),
    .strobe (strobe)
  );

  scanPath #(.ADDR_W(ADDR_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rangeHigh  (rangeHigh),
    .recordBase (recordBase),
    .memData    (memData),
    .memAddr    (memAddr),
    .segOut     (segOut),
    .digitEnN   (digitEnN),
    .dpOut      (dpOut)
  );
endmodule

// File: rtl/scanChecker.sv
module scanChecker #(
  parameter int DWELL_CYCLES = 60000,
  parameter int ADDR_W       = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              locked,
  input logic [ADDR_W-1:0] recordBase,
  input logic [ADDR_W-1:0] memAddr,
  input logic [6:0]        segOut,
  input logic [2:0]        digitEnN,
  input logic              dpOut
);
  localparam int HOLD_W = $clog2(DWELL_CYCLES) + 2;
  localparam logic [HOLD_W-1:0] HOLD_MAX = '1;

  logic [9:0]        prevOut;
  logic [HOLD_W-1:0] holdCnt;
  logic              outMoved;

  assign outMoved = ({segOut, digitEnN} != prevOut);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevOut <= {7'd0, 3'b111};
      holdCnt <= '0;
    end else begin
      prevOut <= {segOut, digitEnN};
      if (!locked || outMoved) holdCnt <= '0;
      else if (holdCnt != HOLD_MAX) holdCnt <= holdCnt + 1'b1;
    end
  end

  p_blank_unlocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !locked |=> (digitEnN == 3'b111 && segOut == 7'd0));

  p_addr_in_record_r2: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, memAddr} >= {1'b0, recordBase}) &&
    ({1'b0, memAddr} <= {1'b0, recordBase} + (ADDR_W+1)'(2)));

  p_addr_single_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(recordBase) && $past(locked) && !$stable(memAddr)) |->
      (memAddr == $past(memAddr) + 1'b1 || memAddr == $past(memAddr) - 1'b1));

  p_one_digit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~digitEnN));

  p_dp_needs_digit_r8: assert property (@(posedge clk) disable iff (!rstN)
    dpOut |-> (digitEnN != 3'b111));

  p_full_dwell_r5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && outMoved && prevOut[2:0] != 3'b111 && digitEnN != 3'b111) |->
      (holdCnt == HOLD_W'(DWELL_CYCLES - 1)));
endmodule

bind pingPongScanner scanChecker #(
  .DWELL_CYCLES(DWELL_CYCLES),
  .ADDR_W      (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .locked     (locked),
  .recordBase (recordBase),
  .memAddr    (memAddr),
  .segOut     (segOut),
  .digitEnN   (digitEnN),
  .dpOut      (dpOut)
);

// File: tb/sim_pingPongScanner.sv
`timescale 1ns/1ps
module sim_pingPongScanner;
  localparam int DW = 8;
  localparam int AW = 10;
  localparam int MEM_N = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN, locked, rangeHigh;
  logic [AW-1:0] recordBase, memAddr;
  logic [11:0]   memData;
  logic [6:0]    segOut;
  logic [2:0]    digitEnN;
  logic          dpOut;
  logic [11:0]   mem [MEM_N];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) memData <= mem[memAddr];

  pingPongScanner #(.DWELL_CYCLES(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .locked(locked), .rangeHigh(rangeHigh),
    .recordBase(recordBase), .memData(memData), .memAddr(memAddr),
    .segOut(segOut), .digitEnN(digitEnN), .dpOut(dpOut)
  );

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int offAt(int i);
    return (i % 4 == 3) ? 1 : (i % 4);
  endfunction

  function automatic logic [2:0] expEn(logic [11:0] w);
    return {w[1], w[2], w[3]};
  endfunction

  function automatic logic expDp(logic [2:0] en, logic rng);
    return rng ? !en[1] : !en[0];
  endfunction

  task automatic checkWord(logic [AW-1:0] base, int off, string when);
    logic [11:0] w;
    w = mem[base + AW'(off)];
    check(segOut == w[11:5], {"R2 seg ", when}, 16'(segOut), 16'(w[11:5]));
    check(digitEnN == expEn(w), {"R3/R4 enables ", when}, 16'(digitEnN), 16'(expEn(w)));
    check(memAddr >= base && memAddr <= base + 2, "R4 address window", 16'(memAddr), 16'(base));
    check(dpOut == expDp(digitEnN, rangeHigh), "R8 dp", 16'(dpOut), 16'(expDp(digitEnN, rangeHigh)));
  endtask

  task automatic runScan(logic [AW-1:0] base, logic rng, int nw);
    @(negedge clk);
    recordBase = base;
    rangeHigh  = rng;
    locked     = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(digitEnN == 3'b111, "R6 still blank before first word", 16'(digitEnN), 16'h7);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < nw; i++) begin
      checkWord(base, offAt(i), "at latch");
      rangeHigh = !rng;
      #1;
      check(dpOut == expDp(digitEnN, !rng), "R8 dp follows switch", 16'(dpOut), 16'(expDp(digitEnN, !rng)));
      rangeHigh = rng;
      repeat (DW - 1) @(negedge clk);
      checkWord(base, offAt(i), "R5 end of dwell");
      @(negedge clk);
    end
  endtask

  task automatic dropLock();
    @(negedge clk);
    locked = 1'b0;
    @(negedge clk);
    check(digitEnN == 3'b111, "R7 enables blank", 16'(digitEnN), 16'h7);
    check(segOut == 7'd0, "R7 segments clear", 16'(segOut), 16'h0);
    check(dpOut == 1'b0, "R8 no dp when blank", 16'(dpOut), 16'h0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    for (int a = 0; a < MEM_N; a++) begin
      mem[a] = 12'($urandom());
      case (a % 3)
        0: mem[a][3:1] = 3'b011;
        1: mem[a][3:1] = 3'b101;
        default: mem[a][3:1] = 3'b110;
      endcase
    end
    rstN = 1'b0; locked = 1'b1; rangeHigh = 1'b0; recordBase = AW'(9);
    repeat (3) @(negedge clk);
    check(digitEnN == 3'b111, "R1 reset enables", 16'(digitEnN), 16'h7);
    check(segOut == 7'd0, "R1 reset segments", 16'(segOut), 16'h0);
    check(dpOut == 1'b0, "R1 reset dp", 16'(dpOut), 16'h0);
    check(memAddr == recordBase, "R1 reset address", 16'(memAddr), 16'(recordBase));
    locked = 1'b0;
    rstN   = 1'b1;
    repeat (2) @(negedge clk);

    runScan(AW'(0), 1'b0, 9);
    dropLock();
    runScan(AW'(3 * 340), 1'b1, 6);
    dropLock();
    runScan(AW'(3 * 17), 1'b0, 3);   // stops while moving down
    dropLock();
    runScan(AW'(3 * 17), 1'b1, 4);   // must restart upward
    dropLock();
    for (int r = 0; r < 10; r++) begin
      runScan(AW'(3 * $urandom_range(0, 340)), 1'($urandom_range(0, 1)), $urandom_range(2, 9));
      repeat ($urandom_range(0, DW)) @(negedge clk);
      dropLock();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule